// File: doc/BRIEF.md
# Service Slave Configuration Table and Address Decoder

This block is the slave-side address decoder of a serial service interface. A single 32-bit word port reaches a 2 MiB byte space, split into three live windows. The lowest kilobyte holds a read-only, self-describing configuration table: the first word identifies the chip and the next words each describe one engine (its type, version, slot count, a check nibble and a flag saying that more entries follow). A second kilobyte window at 0x800 holds general slave-control storage. A third window at 0xc00 is the start of the local bus, where a 256-word scratchpad engine sits at local-bus offset zero.

Writing the magic break word to either of the first two table words resets the local bus: the block raises a one-cycle reset pulse to all local-bus devices and clears its own scratchpad on the edge that follows. Every other write to the table is dropped, and every address outside the three windows reads zero and swallows writes.

Reads return through a registered data path one cycle after the request; writes take effect on the edge that accepts them.

Top module: `svc_slave_decode`

## Requirements
- R1: A read of byte address 0x000 returns the chip identifier 0xc0022d15.
- R2: Engine entries are encoded as bit 31 = more-entries flag (1), bit 16 = slot count (1), bits 15:8 carry the version, bits 7:4 the engine type and bits 3:0 a check nibble; address 0x004 reads 0x8001102c (type 2, version 0x1000, check 0xc), 0x008 reads 0x8001503a (type 3, version 0x5000, check 0xa), 0x00c reads 0x80011067 (type 6, version 0x1000, check 0x7).
- R3: Table addresses 0x010 through 0x3ff read zero.
- R4: A table write of any value other than 0xc0de0000, or of any value to a table address other than 0x000 or 0x004, changes no readable content and raises no local-bus reset.
- R5: Byte addresses 0x800–0xbff are 256 words of read/write storage, zero after reset.
- R6: Byte addresses 0xc00–0xfff are the 256-word scratchpad, read/write, zero after reset.
- R7: A write of 0xc0de0000 to 0x000 or 0x004 drives lbus_rst high for exactly the one cycle following the accepting edge.
- R8: The scratchpad is all zero after the edge at which lbus_rst is high; the slave-control storage is left unchanged by the break.
- R9: Any address outside 0x000–0x3ff, 0x800–0xfff reads zero, and a write there alters no storage.
- R10: rvalid is high exactly in the cycle after a read request, with rdata carrying the addressed word in that cycle; address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 21 | Byte address in the 2 MiB space |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| lbus_rst | output | 1 | One-cycle reset pulse to local-bus devices |

## Verification
Read data is due one cycle after the request edge, so the bench drives a request on a falling edge and samples rdata and rvalid on the next falling edge, after exactly one rising edge. The break pulse appears in the cycle after the break write is accepted and the scratchpad clear lands on the edge after that; the bench therefore checks lbus_rst one half-cycle after the write edge, checks it low one cycle later, and only then reads the scratchpad back. Ignored writes are checked by reading back the table, control and scratchpad words they could have disturbed before any other write.

// File: rtl/svc_slave_decode.sv
module svc_slave_decode #(
  parameter int          ADDR_W     = 21,
  parameter int          WIN_WORDS  = 256,
  parameter logic [31:0] CHIP_ID    = 32'hc0022d15,
  parameter logic [31:0] BREAK_WORD = 32'hc0de0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic              lbus_rst
);

  localparam int IDX_W   = $clog2(WIN_WORDS);
  localparam int WIN_LSB = IDX_W + 2;
  localparam int SEL_W   = ADDR_W - WIN_LSB;

  localparam logic [SEL_W-1:0] SEL_TBL  = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_SCR  = SEL_W'(3);

  function automatic logic [31:0] engine_entry(input logic [15:0] ver,
                                               input logic [3:0] kind,
                                               input logic [3:0] chk);
    return 32'h8000_0000 | 32'h0001_0000 | {16'h0, ver} | {24'h0, kind, 4'h0} | {28'h0, chk};
  endfunction

  logic [31:0] ctrl_mem [WIN_WORDS];
  logic [31:0] scr_mem  [WIN_WORDS];

  wire [SEL_W-1:0] sel = addr[ADDR_W-1:WIN_LSB];
  wire [IDX_W-1:0] idx = addr[WIN_LSB-1:2];

  wire tbl_hit  = (sel == SEL_TBL);
  wire ctrl_hit = (sel == SEL_CTRL);
  wire scr_hit  = (sel == SEL_SCR);

  wire rd_req = req && !we;
  wire wr_req = req && we;
  wire brk_wr = wr_req && tbl_hit && (idx < IDX_W'(2)) && (wdata == BREAK_WORD);

  logic [31:0] tbl_word;
  always_comb begin
    case (idx)
      IDX_W'(0): tbl_word = CHIP_ID;
      IDX_W'(1): tbl_word = engine_entry(16'h1000, 4'h2, 4'hc);
      IDX_W'(2): tbl_word = engine_entry(16'h5000, 4'h3, 4'ha);
      IDX_W'(3): tbl_word = engine_entry(16'h1000, 4'h6, 4'h7);
      default:   tbl_word = 32'h0;
    endcase
  end

  logic [31:0] rd_mux;
  always_comb begin
    if (tbl_hit)       rd_mux = tbl_word;
    else if (ctrl_hit) rd_mux = ctrl_mem[idx];
    else if (scr_hit)  rd_mux = scr_mem[idx];
    else               rd_mux = 32'h0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid   <= 1'b0;
      rdata    <= 32'h0;
      lbus_rst <= 1'b0;
      for (int i = 0; i < WIN_WORDS; i++) begin
        ctrl_mem[i] <= 32'h0;
        scr_mem[i]  <= 32'h0;
      end
    end else begin
      rvalid   <= rd_req;
      lbus_rst <= brk_wr;
      if (rd_req) rdata <= rd_mux;
      if (wr_req && ctrl_hit) ctrl_mem[idx] <= wdata;
      if (lbus_rst) begin
        for (int i = 0; i < WIN_WORDS; i++) scr_mem[i] <= 32'h0;
      end else if (wr_req && scr_hit) begin
        scr_mem[idx] <= wdata;
      end
    end
  end

  // R10: read handshake timing
  a_r10_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rvalid);
  a_r10_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rvalid);

  // R1: identifier word
  a_r1_chip_id: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && tbl_hit && idx == IDX_W'(0)) |=> (rdata == CHIP_ID));

  // R3 / R9: empty table words and undecoded space read zero
  a_r3_table_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && tbl_hit && idx > IDX_W'(3)) |=> (rdata == 32'h0));
  a_r9_undecoded_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !tbl_hit && !ctrl_hit && !scr_hit) |=> (rdata == 32'h0));

  // R7: break pulse
  a_r7_break_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    brk_wr |=> lbus_rst);
  a_r7_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_wr |=> !lbus_rst);

  // R8: scratchpad cleared, control storage kept
  a_r8_scratch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    lbus_rst |=> (scr_mem[0] == 32'h0 && scr_mem[WIN_WORDS-1] == 32'h0));
  a_r8_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (lbus_rst && !wr_req) |=> ($stable(ctrl_mem[0]) && $stable(ctrl_mem[WIN_WORDS-1])));

endmodule

// File: tb/svc_slave_decode_tb.sv
module svc_slave_decode_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [20:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        lbus_rst;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  svc_slave_decode u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .lbus_rst(lbus_rst)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [20:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [20:0] a, input logic [31:0] exp);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    check({tag, " rvalid"}, {31'h0, rvalid}, 32'h1);
    check(tag, rdata, exp);
  endtask

  task automatic t_reset_state;
    check("R7 lbus_rst after reset", {31'h0, lbus_rst}, 32'h0);
    check("R10 rvalid after reset", {31'h0, rvalid}, 32'h0);
    rd("R5 ctrl reset zero", 21'h800, 32'h0);
    rd("R6 scratch reset zero", 21'hffc, 32'h0);
  endtask

  task automatic t_table;
    rd("R1 chip id", 21'h000, 32'hc0022d15);
    rd("R2 peek entry", 21'h004, 32'h8001102c);
    rd("R2 link entry", 21'h008, 32'h8001503a);
    rd("R2 scratch entry", 21'h00c, 32'h80011067);
    rd("R10 low addr bits ignored", 21'h00b, 32'h8001503a);
    rd("R3 table 0x010 zero", 21'h010, 32'h0);
    rd("R3 table 0x3fc zero", 21'h3fc, 32'h0);
  endtask

  task automatic t_storage;
    wr(21'h800, 32'h1234_5678);
    wr(21'hbfc, 32'hdead_beef);
    wr(21'hc00, 32'hcafe_f00d);
    wr(21'hffc, 32'h0bad_c0de);
    rd("R5 ctrl first word", 21'h800, 32'h1234_5678);
    rd("R5 ctrl last word", 21'hbfc, 32'hdead_beef);
    rd("R6 scratch first word", 21'hc00, 32'hcafe_f00d);
    rd("R6 scratch last word", 21'hffc, 32'h0bad_c0de);
  endtask

  task automatic t_ignored_table_writes;
    wr(21'h000, 32'h1111_2222);
    check("R4 no pulse on plain table write", {31'h0, lbus_rst}, 32'h0);
    rd("R4 chip id kept", 21'h000, 32'hc0022d15);
    wr(21'h008, 32'hc0de0000);
    check("R4 no pulse on break word at 0x008", {31'h0, lbus_rst}, 32'h0);
    rd("R4 link entry kept", 21'h008, 32'h8001503a);
    rd("R4 scratch kept", 21'hc00, 32'hcafe_f00d);
    wr(21'h020, 32'hffff_ffff);
    rd("R4 table tail still zero", 21'h020, 32'h0);
  endtask

  task automatic t_undecoded;
    wr(21'h400, 32'h5555_aaaa);
    rd("R9 hole 0x400 zero", 21'h400, 32'h0);
    wr(21'h1000, 32'h7777_7777);
    rd("R9 0x1000 zero", 21'h1000, 32'h0);
    rd("R9 scratch untouched by 0x1000 write", 21'hc00, 32'hcafe_f00d);
    rd("R9 ctrl untouched", 21'h800, 32'h1234_5678);
    rd("R9 top of space zero", 21'h1ffffc, 32'h0);
  endtask

  task automatic t_break(input logic [20:0] a);
    wr(21'hc40, 32'h4242_4242);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = 32'hc0de0000;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    check("R7 pulse high after break", {31'h0, lbus_rst}, 32'h1);
    @(negedge clk);
    check("R7 pulse one cycle only", {31'h0, lbus_rst}, 32'h0);
    rd("R8 scratch cleared first", 21'hc00, 32'h0);
    rd("R8 scratch cleared written", 21'hc40, 32'h0);
    rd("R8 scratch cleared last", 21'hffc, 32'h0);
    rd("R8 ctrl kept first", 21'h800, 32'h1234_5678);
    rd("R8 ctrl kept last", 21'hbfc, 32'hdead_beef);
  endtask

  task automatic t_rvalid_idle;
    wr(21'hc08, 32'h0000_0001);
    check("R10 no rvalid after write", {31'h0, rvalid}, 32'h0);
    rd("R6 scratch usable after break", 21'hc08, 32'h0000_0001);
    @(negedge clk);
    check("R10 rvalid drops when idle", {31'h0, rvalid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_table();
    t_storage();
    t_ignored_table_writes();
    t_undecoded();
    t_break(21'h000);
    wr(21'hc00, 32'hcafe_f00d);
    t_break(21'h004);
    t_rvalid_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule